// File: doc/BRIEF.md
# Block Protection Tuple Checker

This block sits in the data path of a storage controller and inspects each logical block as it streams past one byte per clock. A block is a fixed number of data bytes followed by an 8-byte protection tuple. The tuple holds a 16-bit guard, a 16-bit application tag and a 32-bit reference tag. The checker runs a CRC over the data bytes and compares it with the guard. Depending on the protection type, it also compares the reference tag with an expected value that advances by one for each block of the command.

A command is opened with a one-cycle `cmd_start` pulse. That pulse latches the protection type, the direction, the low word of the starting block address and the two candidate initial tags. For each block, the block gives a one-cycle status pulse with separate guard and reference-tag error bits. Errors are only reported; the data is never changed. Host handling of those errors is left to the surrounding logic.

Top module: `prot_tuple_checker`

## Requirements
- R1: The guard check uses CRC-16 with polynomial 0x8BB7, initial value 0, most significant bit first and no reflection, over the block's data bytes in arrival order. A mismatch with the guard field sets `st_guard_err` in that block's status pulse.
- R2: The tuple arrives big-endian. The first two bytes are the guard (high byte first), the next two are the application tag, and the last four are the reference tag (high byte first). The application tag never affects the status.
- R3: `st_valid` is high for exactly one cycle: the cycle after the block's last tuple byte is accepted. Both error bits are low whenever `st_valid` is low.
- R4: With protection type code 1, the reference tag must equal the low 32 bits of (starting block address + block index within the command).
- R5: With type code 2, the expected reference tag is the initial tag selected by direction plus the block index. A read uses `cmd_tag_expect` and a write uses `cmd_tag_init`.
- R6: With type code 3, the reference tag is not compared and only the guard is checked.
- R7: With type code 0, no field is checked. Each block still produces a status pulse, with both error bits clear.
- R8: The block index starts at 0 for each command and rises by 1 per completed block, wrapping modulo 2^32.
- R9: `cmd_start` discards any partly received block without a status pulse and clears the CRC and byte position. A byte offered in the same cycle as `cmd_start` is dropped.
- R10: Cycles with `in_valid` low change no state, so idle gaps anywhere in a block leave the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Opens a command and latches the configuration below |
| cmd_ptype | input | 2 | Protection type code 0..3 |
| cmd_is_read | input | 1 | 1 for a read command, 0 for a write |
| cmd_lba_lo | input | 32 | Low 32 bits of the starting block address |
| cmd_tag_init | input | 32 | Initial reference tag used on writes (type 2) |
| cmd_tag_expect | input | 32 | Expected initial reference tag used on reads (type 2) |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_byte | input | 8 | Data or tuple byte |
| st_valid | output | 1 | One-cycle per-block status strobe |
| st_guard_err | output | 1 | Guard mismatch for the block |
| st_ref_err | output | 1 | Reference tag mismatch for the block |

## Verification
The only timed result is the status strobe. It is registered once after the cycle that accepts the final tuple byte, so it is due exactly one cycle later. The bench samples it 1 ns after the clock edge that takes that byte. One cycle further on, it confirms the strobe has dropped. During the tuple it also confirms that no early strobe appeared, including in blocks with inserted idle gaps. The sweep covers every type code, both directions, four error patterns and three blocks per command, and starts near a 32-bit wrap of the block address.

// File: rtl/pi_chk_pkg.sv
package pi_chk_pkg;
   typedef enum logic [1:0] {
      PT_NONE = 2'd0,
      PT_T1   = 2'd1,
      PT_T2   = 2'd2,
      PT_T3   = 2'd3
   } prot_t;

   localparam int TUPLE_BYTES = 8;
   localparam int GUARD_W     = 16;
   localparam int REF_W       = 32;
endpackage

// File: rtl/pi_crc_step.sv
module pi_crc_step #(
   parameter int              W    = 16,
   parameter logic [W-1:0]    POLY = 16'h8BB7
) (
   input  logic [W-1:0] crc_in,
   input  logic [7:0]   din,
   output logic [W-1:0] crc_out
);
   generate
      if (W < 8) begin : g_bad_w
         $error("pi_crc_step: W must be at least 8");
      end
   endgenerate

   logic [W-1:0] stage [0:8];

   assign stage[0] = crc_in ^ (W'(din) << (W - 8));

   generate
      for (genvar b = 0; b < 8; b++) begin : g_bit
         assign stage[b+1] = stage[b][W-1] ? ((stage[b] << 1) ^ POLY)
                                           : (stage[b] << 1);
      end
   endgenerate

   assign crc_out = stage[8];
endmodule

// File: rtl/pi_byte_seq.sv
module pi_byte_seq
   import pi_chk_pkg::*;
#(
   parameter int BLOCK_BYTES = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   output logic              data_beat,
   output logic              tuple_last,
   output logic [GUARD_W-1:0] tuple_guard,
   output logic [REF_W-1:0]  tuple_ref
);
   localparam int TOTAL = BLOCK_BYTES + TUPLE_BYTES;
   localparam int PW    = $clog2(TOTAL);
   localparam logic [PW-1:0] DLIM = PW'(BLOCK_BYTES);
   localparam logic [PW-1:0] LAST = PW'(TOTAL - 1);
   localparam int SR_W  = 8 * (TUPLE_BYTES - 1);

   generate
      if (BLOCK_BYTES < 1) begin : g_bad_bb
         $error("pi_byte_seq: BLOCK_BYTES must be positive");
      end
   endgenerate

   logic [PW-1:0]   pos_q;
   logic [SR_W-1:0] sr_q;
   logic            take;

   assign take       = in_valid && !restart;
   assign data_beat  = take && (pos_q < DLIM);
   assign tuple_last = take && (pos_q == LAST);
   assign tuple_guard = sr_q[SR_W-1 -: GUARD_W];
   assign tuple_ref   = {sr_q[REF_W-9:0], in_byte};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         sr_q  <= '0;
      end else if (restart) begin
         pos_q <= '0;
         sr_q  <= '0;
      end else if (take) begin
         pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
         if (pos_q >= DLIM) begin
            sr_q <= {sr_q[SR_W-9:0], in_byte};
         end
      end
   end

   a_r10_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= LAST);
   a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> pos_q == '0);
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !restart) |=> $stable(pos_q));
endmodule

// File: rtl/pi_reftag_gen.sv
module pi_reftag_gen
   import pi_chk_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  prot_t            ptype_in,
   input  logic             is_read,
   input  logic [REF_W-1:0] lba_lo,
   input  logic [REF_W-1:0] tag_init,
   input  logic [REF_W-1:0] tag_expect,
   input  logic             advance,
   output prot_t            ptype,
   output logic [REF_W-1:0] exp_tag
);
   logic [REF_W-1:0] base_q;
   logic [REF_W-1:0] idx_q;
   prot_t            ptype_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         idx_q   <= '0;
         ptype_q <= PT_NONE;
      end else if (restart) begin
         ptype_q <= ptype_in;
         idx_q   <= '0;
         if (ptype_in == PT_T1) base_q <= lba_lo;
         else                   base_q <= is_read ? tag_expect : tag_init;
      end else if (advance) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   assign ptype   = ptype_q;
   assign exp_tag = base_q + idx_q;

   a_r8_index_step: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !restart) |=> idx_q == $past(idx_q) + 1'b1);
   a_r8_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> idx_q == '0);
endmodule

// File: rtl/prot_tuple_checker.sv
module prot_tuple_checker
   import pi_chk_pkg::*;
#(
   parameter int                 BLOCK_BYTES = 512,
   parameter logic [GUARD_W-1:0] GUARD_POLY  = 16'h8BB7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_start,
   input  logic [1:0]  cmd_ptype,
   input  logic        cmd_is_read,
   input  logic [31:0] cmd_lba_lo,
   input  logic [31:0] cmd_tag_init,
   input  logic [31:0] cmd_tag_expect,
   input  logic        in_valid,
   input  logic [7:0]  in_byte,
   output logic        st_valid,
   output logic        st_guard_err,
   output logic        st_ref_err
);
   logic               data_beat, tuple_last;
   logic [GUARD_W-1:0] tuple_guard, crc_q, crc_next;
   logic [REF_W-1:0]   tuple_ref, exp_tag;
   prot_t              ptype;
   logic               chk_guard, chk_ref;

   pi_byte_seq #(.BLOCK_BYTES(BLOCK_BYTES)) u_seq (
      .clk(clk), .rst_n(rst_n), .restart(cmd_start),
      .in_valid(in_valid), .in_byte(in_byte),
      .data_beat(data_beat), .tuple_last(tuple_last),
      .tuple_guard(tuple_guard), .tuple_ref(tuple_ref)
   );

   pi_crc_step #(.W(GUARD_W), .POLY(GUARD_POLY)) u_crc (
      .crc_in(crc_q), .din(in_byte), .crc_out(crc_next)
   );

   pi_reftag_gen u_ref (
      .clk(clk), .rst_n(rst_n), .restart(cmd_start),
      .ptype_in(prot_t'(cmd_ptype)), .is_read(cmd_is_read),
      .lba_lo(cmd_lba_lo), .tag_init(cmd_tag_init),
      .tag_expect(cmd_tag_expect), .advance(tuple_last),
      .ptype(ptype), .exp_tag(exp_tag)
   );

   assign chk_guard = (ptype != PT_NONE);
   assign chk_ref   = (ptype == PT_T1) || (ptype == PT_T2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q        <= '0;
         st_valid     <= 1'b0;
         st_guard_err <= 1'b0;
         st_ref_err   <= 1'b0;
      end else begin
         if (cmd_start || tuple_last) crc_q <= '0;
         else if (data_beat)          crc_q <= crc_next;
         st_valid     <= tuple_last;
         st_guard_err <= tuple_last && chk_guard && (tuple_guard != crc_q);
         st_ref_err   <= tuple_last && chk_ref && (tuple_ref != exp_tag);
      end
   end

   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |=> !st_valid);
   a_r3_quiet_errs: assert property (@(posedge clk) disable iff (!rst_n)
      !st_valid |-> !(st_guard_err || st_ref_err));
   a_r6_ref_types: assert property (@(posedge clk) disable iff (!rst_n)
      st_ref_err |-> (ptype == PT_T1 || ptype == PT_T2));
   a_r7_none_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && ptype == PT_NONE) |-> !st_guard_err);
   a_r9_no_pulse_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> !st_valid);
endmodule

// File: tb/prot_tuple_checker_test.sv
module prot_tuple_checker_test;
   localparam int BB = 4;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        cmd_start = 0;
   logic [1:0]  cmd_ptype = 0;
   logic        cmd_is_read = 0;
   logic [31:0] cmd_lba_lo = 0, cmd_tag_init = 0, cmd_tag_expect = 0;
   logic        in_valid = 0;
   logic [7:0]  in_byte = 0;
   logic        st_valid, st_guard_err, st_ref_err;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   prot_tuple_checker #(.BLOCK_BYTES(BB)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_ptype(cmd_ptype),
      .cmd_is_read(cmd_is_read), .cmd_lba_lo(cmd_lba_lo),
      .cmd_tag_init(cmd_tag_init), .cmd_tag_expect(cmd_tag_expect),
      .in_valid(in_valid), .in_byte(in_byte),
      .st_valid(st_valid), .st_guard_err(st_guard_err), .st_ref_err(st_ref_err)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_model(input logic [7:0] d [BB]);
      logic [15:0] c = 16'h0000;
      for (int i = 0; i < BB; i++) begin
         c = c ^ {d[i], 8'h00};
         for (int b = 0; b < 8; b++)
            c = c[15] ? ((c << 1) ^ 16'h8BB7) : (c << 1);
      end
      return c;
   endfunction

   task automatic open_cmd(input logic [1:0] pt, input bit rd,
                           input logic [31:0] lba, input logic [31:0] ini,
                           input logic [31:0] ex);
      @(negedge clk);
      cmd_start = 1; cmd_ptype = pt; cmd_is_read = rd;
      cmd_lba_lo = lba; cmd_tag_init = ini; cmd_tag_expect = ex;
      @(negedge clk);
      cmd_start = 0;
      cmd_ptype = ~pt; cmd_is_read = ~rd;
   endtask

   // sends one block; returns sampled status one cycle after last tuple byte
   task automatic send_block(input logic [7:0] seed, input bit bad_g,
                             input logic [31:0] rtag, input logic [15:0] app,
                             input bit gaps, output logic [2:0] st);
      logic [7:0] d [BB];
      logic [7:0] s [BB+8];
      logic [15:0] g;
      for (int i = 0; i < BB; i++) d[i] = 8'(seed * 8'd29 + i * 71 + 5);
      g = crc_model(d) ^ (bad_g ? 16'h0100 : 16'h0000);
      for (int i = 0; i < BB; i++) s[i] = d[i];
      s[BB]   = g[15:8];    s[BB+1] = g[7:0];
      s[BB+2] = app[15:8];  s[BB+3] = app[7:0];
      s[BB+4] = rtag[31:24]; s[BB+5] = rtag[23:16];
      s[BB+6] = rtag[15:8];  s[BB+7] = rtag[7:0];
      for (int i = 0; i < BB + 8; i++) begin
         @(negedge clk);
         if (i == BB + 3)
            chk(st_valid == 1'b0, "R3 no early strobe", st_valid, 0);
         if (gaps && (i == 1 || i == BB + 1)) begin
            in_valid = 0; in_byte = 8'hA5;
            @(negedge clk);
         end
         in_valid = 1; in_byte = s[i];
      end
      @(posedge clk); #1;
      st = {st_valid, st_guard_err, st_ref_err};
      @(negedge clk);
      in_valid = 0;
      @(posedge clk); #1;
      chk(st_valid == 1'b0, "R3 strobe one cycle", st_valid, 0);
   endtask

   initial begin
      logic [2:0] st;
      logic [31:0] lba, ini, ex, want, rt;
      bit bg, br, eg, er;
      #1;
      chk(st_valid == 0 && st_guard_err == 0 && st_ref_err == 0,
          "R3 reset state", {st_valid, st_guard_err, st_ref_err}, 0);
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      @(posedge clk); #1;
      chk(st_valid == 0, "R3 after reset", st_valid, 0);

      lba = 32'hFFFF_FFFE;
      for (int pt = 0; pt < 4; pt++) begin
         for (int rd = 0; rd < 2; rd++) begin
            for (int m = 0; m < 4; m++) begin
               ini = 32'hA000_0100 + pt;
               ex  = 32'h5000_7F00 + pt * 3;
               open_cmd(2'(pt), rd[0], lba, ini, ex);
               for (int k = 0; k < 3; k++) begin
                  bg = m[0];
                  br = m[1];
                  if (pt == 1)      want = lba + k;       // R4
                  else if (rd == 1) want = ex + k;        // R5 read
                  else              want = ini + k;       // R5 write
                  rt = br ? (want ^ 32'h0000_0100) : want;
                  if (pt == 3 && !br) rt = 32'hDEAD_0000 + k; // R6 ignored
                  send_block(8'(pt * 16 + rd * 8 + m * 2 + k), bg, rt,
                             {8'(k), 8'(m * 37)}, k == 1, st);
                  eg = (pt != 0) && bg;
                  er = (pt == 1 || pt == 2) && br;
                  chk(st[2] == 1'b1, "R3 strobe due", st[2], 1);
                  chk(st[1] == eg, pt == 0 ? "R7 guard off" : "R1 guard", st[1], eg);
                  chk(st[0] == er, pt == 3 ? "R6 ref ignored" :
                      (pt == 0 ? "R7 ref off" : "R8 ref index"), st[0], er);
               end
            end
         end
      end

      // R2: application tag never matters
      open_cmd(2'd1, 1'b0, 32'h0000_1000, 0, 0);
      send_block(8'h3C, 0, 32'h0000_1000, 16'hFFFF, 0, st);
      chk(st == 3'b100, "R2 app tag ignored", st, 3'b100);

      // R9: abort partial block, then a clean block
      open_cmd(2'd1, 1'b1, 32'h0000_2000, 0, 0);
      for (int i = 0; i < BB + 2; i++) begin
         @(negedge clk); in_valid = 1; in_byte = 8'h77;
      end
      @(negedge clk);
      in_valid = 1; in_byte = 8'h11;
      cmd_start = 1; cmd_ptype = 2'd1; cmd_lba_lo = 32'h0000_3000;
      @(posedge clk); #1;
      chk(st_valid == 0, "R9 no strobe on abort", st_valid, 0);
      @(negedge clk);
      cmd_start = 0; in_valid = 0;
      send_block(8'h42, 0, 32'h0000_3000, 16'h0, 0, st);
      chk(st == 3'b100, "R9 restart clean", st, 3'b100);
      send_block(8'h43, 0, 32'h0000_3001, 16'h0, 1, st);
      chk(st == 3'b100, "R10 gaps second block", st, 3'b100);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule